// File: doc/BRIEF.md
# Cyclic Ring-Buffer DMA Channel

This block is one DMA channel that moves 32-bit words without end between a ring buffer in memory and a peripheral stream. The ring is divided into between one and eight equal periods, and each period holds a whole number of words. Software programs the channel through a small word-wide register file. It sets the direction, the ring base, the period length, the period count and the burst length, and then starts the channel. From then on the channel walks the ring on its own. After the last word of the last period it returns to the base address.

Every completed period sets an interrupt flag and advances a wrapping 16-bit counter of completed periods. Software reads that counter to follow progress through the ring. The channel can be paused and stopped. Both requests act only at a burst boundary, so a burst is never cut in half. On the memory side the channel uses a single-word request/grant port. On the peripheral side it uses a valid/ready stream.

Everything is sequenced by one state machine with these states:
- `S_IDLE`: the channel is stopped.
- `S_MEM_RD`: memory read is requested.
- `S_PERI_TX`: a word is offered on the outgoing stream.
- `S_PERI_RX`: a word is awaited on the incoming stream.
- `S_MEM_WR`: memory write is requested.
- `S_PAUSED`: the channel is held at a burst boundary.

Its transitions are:
- start: `S_IDLE` goes to `S_MEM_RD` or `S_PERI_RX`, depending on direction.
- read granted: `S_MEM_RD` goes to `S_PERI_TX`.
- word received: `S_PERI_RX` goes to `S_MEM_WR`.
- word done inside a burst: the channel goes back to the first state of its direction.
- word done at a boundary: the channel goes to `S_IDLE` if run is off, to `S_PAUSED` if a pause is requested, and otherwise to the first state of its direction.
- in `S_PAUSED`: the channel goes to `S_IDLE` when run drops, and back to the first state of its direction when the pause request is cleared.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the command (0x00), status (0x0c), interrupt status (0x10) and progress (0x54) registers read 0, irq is low and no memory request or stream handshake is active.
- R2: Writing 1 to bit 0 of the command register starts the channel only if the direction field is 2 or 4 and the transfer count is non-zero. Otherwise the start is refused and status bit 0 stays 0. While the channel runs, status bit 0 reads 1. Writing 0 stops the channel at the next burst boundary, with no word lost or repeated, and status bit 0 then falls to 0.
- R3: With control bits 15:12 equal to 4 (memory to peripheral), the channel reads words from the address in the source register (0x34) upward and presents them on tx_data in the same order.
- R4: With control bits 15:12 equal to 2 (peripheral to memory), the channel writes the words accepted on rx_data, in arrival order, to the address in the target register (0x3c) upward.
- R5: The period length in words is taken from bits 29:2 of the transfer count (0x44). The number of periods is one more than config bits 30:28 for memory to peripheral, or config bits 26:24 for peripheral to memory (config at 0x28). After the last word of the last period, the address returns to the base and the channel continues with no software action.
- R6: The burst length is one more than config bits 23:20. Setting control bit 0 (0x24) pauses the channel at the next burst boundary. While paused, status bit 1 reads 1 and there is no memory or stream activity. Clearing control bit 0 resumes the channel at the next word in sequence.
- R7: Interrupt status bit 0 and irq are set each time a period completes. Writing 1 to bit 0 at 0x1c clears them.
- R8: The progress register counts completed periods. It is 16 bits wide, wraps from 0xFFFF to 0, and is cleared at each start.
- R9: When control bit 1 is 1, a stream word moves only when tx_ready (or rx_valid) is high, and tx_data holds steady while it waits. When control bit 1 is 0, each stream beat completes in one cycle regardless of the peer.
- R10: A memory request keeps its address, direction and data unchanged until it is granted. Memory addresses are always word aligned, and bits 1:0 of the source and target registers read 0.
- R11: The direction, base address, period length, period count and burst length are captured at start. Writes to them during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Period-complete interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; read data is valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_ready | input | 1 | Peripheral accepts the outgoing word |
| tx_data | output | 32 | Outgoing stream word |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_ready | output | 1 | Channel accepts the incoming word |
| rx_data | input | 32 | Incoming stream word |

## Verification
A wrong word or period counter shows up on the ports within one ring lap. It appears either as a stream word that does not match the ring position it should come from, or as a memory access outside the programmed ring. An error in the burst counter shows up at the first pause or stop: the number of words moved before status settles is then not a whole number of bursts or periods. A wrong state transition either leaves a request or handshake active while status reports idle or paused, or leaves the progress count different from the number of completed periods that the bench counted.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    // Register byte offsets; software decodes these.
    localparam logic [7:0] OFS_CMD    = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_ISR    = 8'h10;
    localparam logic [7:0] OFS_ICLR   = 8'h1C;
    localparam logic [7:0] OFS_CTRL   = 8'h24;
    localparam logic [7:0] OFS_CFG    = 8'h28;
    localparam logic [7:0] OFS_SRC    = 8'h34;
    localparam logic [7:0] OFS_DST    = 8'h3C;
    localparam logic [7:0] OFS_TC     = 8'h44;
    localparam logic [7:0] OFS_PROG   = 8'h54;

    // Field positions
    localparam int CTRL_DIR_LSB  = 12;
    localparam int CTRL_MODE_LSB = 8;
    localparam int CTRL_FLOW_BIT = 1;
    localparam int CTRL_HOLD_BIT = 0;
    localparam int CFG_TXPER_LSB = 28;
    localparam int CFG_RXPER_LSB = 24;
    localparam int CFG_BURST_LSB = 20;
    localparam int TC_LSB        = 2;

    // Direction codes
    localparam logic [3:0] DIR_P2M = 4'd2;
    localparam logic [3:0] DIR_M2P = 4'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MEM_RD,
        S_PERI_TX,
        S_PERI_RX,
        S_MEM_WR,
        S_PAUSED
    } chan_state_e;

endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
    import ring_dma_pkg::*;
#(
    parameter int LEN_W   = 28,
    parameter int PER_W   = 3,
    parameter int BURST_W = 4,
    parameter int PROG_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic               paused,
    input  logic               period_done,
    input  logic [PROG_W-1:0]  progress,
    output logic               start,
    output logic               run,
    output logic               pause_req,
    output logic               flow_en,
    output logic               dir_m2p,
    output logic [31:0]        base,
    output logic [LEN_W-1:0]   period_words,
    output logic [PER_W-1:0]   last_period,
    output logic [BURST_W-1:0] burst_m1,
    output logic               irq
);

    logic               run_q, hold_q, flow_q, isr_q;
    logic [1:0]         mode_q;
    logic [3:0]         dir_q;
    logic [PER_W-1:0]   txper_q, rxper_q;
    logic [BURST_W-1:0] burst_q;
    logic [LEN_W-1:0]   tc_q;
    logic [29:0]        src_q, dst_q;
    logic               cfg_ok, wr_cmd;

    assign cfg_ok = ((dir_q == DIR_M2P) || (dir_q == DIR_P2M)) && (tc_q != '0);
    assign wr_cmd = reg_we && (reg_addr == OFS_CMD);
    assign start  = wr_cmd && reg_wdata[0] && cfg_ok && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            hold_q  <= 1'b0;
            flow_q  <= 1'b0;
            mode_q  <= '0;
            dir_q   <= '0;
            txper_q <= '0;
            rxper_q <= '0;
            burst_q <= '0;
            tc_q    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CMD:  run_q <= reg_wdata[0] && (cfg_ok || busy);
                OFS_CTRL: begin
                    dir_q  <= reg_wdata[CTRL_DIR_LSB +: 4];
                    mode_q <= reg_wdata[CTRL_MODE_LSB +: 2];
                    flow_q <= reg_wdata[CTRL_FLOW_BIT];
                    hold_q <= reg_wdata[CTRL_HOLD_BIT];
                end
                OFS_CFG: begin
                    txper_q <= reg_wdata[CFG_TXPER_LSB +: PER_W];
                    rxper_q <= reg_wdata[CFG_RXPER_LSB +: PER_W];
                    burst_q <= reg_wdata[CFG_BURST_LSB +: BURST_W];
                end
                OFS_TC:  tc_q  <= reg_wdata[TC_LSB +: LEN_W];
                OFS_SRC: src_q <= reg_wdata[31:2];
                OFS_DST: dst_q <= reg_wdata[31:2];
                default: ;
            endcase
        end
    end

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            isr_q <= 1'b0;
        else if (period_done)
            isr_q <= 1'b1;
        else if (reg_we && (reg_addr == OFS_ICLR) && reg_wdata[0])
            isr_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:    reg_rdata[0] = run_q;
            OFS_STATUS: reg_rdata[1:0] = {paused, busy};
            OFS_ISR:    reg_rdata[0] = isr_q;
            OFS_CTRL: begin
                reg_rdata[CTRL_DIR_LSB +: 4]  = dir_q;
                reg_rdata[CTRL_MODE_LSB +: 2] = mode_q;
                reg_rdata[CTRL_FLOW_BIT]      = flow_q;
                reg_rdata[CTRL_HOLD_BIT]      = hold_q;
            end
            OFS_CFG: begin
                reg_rdata[CFG_TXPER_LSB +: PER_W]   = txper_q;
                reg_rdata[CFG_RXPER_LSB +: PER_W]   = rxper_q;
                reg_rdata[CFG_BURST_LSB +: BURST_W] = burst_q;
            end
            OFS_TC:   reg_rdata[TC_LSB +: LEN_W] = tc_q;
            OFS_SRC:  reg_rdata = {src_q, 2'b00};
            OFS_DST:  reg_rdata = {dst_q, 2'b00};
            OFS_PROG: reg_rdata[PROG_W-1:0] = progress;
            default:  reg_rdata = '0;
        endcase
    end

    assign run          = run_q;
    assign pause_req    = hold_q;
    assign flow_en      = flow_q;
    assign dir_m2p      = (dir_q == DIR_M2P);
    assign base         = dir_m2p ? {src_q, 2'b00} : {dst_q, 2'b00};
    assign period_words = tc_q;
    assign last_period  = dir_m2p ? txper_q : rxper_q;
    assign burst_m1     = burst_q;
    assign irq          = isr_q;

endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
    import ring_dma_pkg::*;
#(
    parameter int DW      = 32,
    parameter int LEN_W   = 28,
    parameter int PER_W   = 3,
    parameter int BURST_W = 4,
    parameter int PROG_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic               pause_req,
    input  logic               flow_en,
    input  logic               dir_m2p,
    input  logic [31:0]        base,
    input  logic [LEN_W-1:0]   period_words,
    input  logic [PER_W-1:0]   last_period,
    input  logic [BURST_W-1:0] burst_m1,
    output logic               busy,
    output logic               paused,
    output logic               period_done,
    output logic [PROG_W-1:0]  progress,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_gnt,
    input  logic [DW-1:0]      mem_rdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [DW-1:0]      tx_data,
    input  logic               rx_valid,
    output logic               rx_ready,
    input  logic [DW-1:0]      rx_data
);

    localparam logic [31:0] WORD_BYTES = 32'd4;

    chan_state_e        state_q, state_d, resume_st, after_word;
    logic               m2p_q;
    logic [31:0]        base_q, addr_q;
    logic [LEN_W-1:0]   plen_q, word_q;
    logic [PER_W-1:0]   lastp_q, per_q;
    logic [BURST_W-1:0] burst_q, beat_q;
    logic [PROG_W-1:0]  prog_q;
    logic [DW-1:0]      hold_q;
    logic               word_done, last_word, at_edge;

    always_comb begin
        word_done   = ((state_q == S_PERI_TX) && (tx_ready || !flow_en)) ||
                      ((state_q == S_MEM_WR) && mem_gnt);
        last_word   = (word_q == plen_q - 1'b1);
        at_edge     = word_done && (last_word || (beat_q == burst_q));
        period_done = word_done && last_word;
        resume_st   = m2p_q ? S_MEM_RD : S_PERI_RX;
        if (!at_edge)       after_word = resume_st;
        else if (!run)      after_word = S_IDLE;
        else if (pause_req) after_word = S_PAUSED;
        else                after_word = resume_st;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = dir_m2p ? S_MEM_RD : S_PERI_RX;
            S_MEM_RD:  if (mem_gnt) state_d = S_PERI_TX;
            S_PERI_TX: if (word_done) state_d = after_word;
            S_PERI_RX: if (rx_valid || !flow_en) state_d = S_MEM_WR;
            S_MEM_WR:  if (word_done) state_d = after_word;
            S_PAUSED: begin
                if (!run)            state_d = S_IDLE;
                else if (!pause_req) state_d = resume_st;
            end
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Ring position, captured settings and data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m2p_q   <= 1'b0;
            base_q  <= '0;
            addr_q  <= '0;
            plen_q  <= '0;
            word_q  <= '0;
            lastp_q <= '0;
            per_q   <= '0;
            burst_q <= '0;
            beat_q  <= '0;
            prog_q  <= '0;
            hold_q  <= '0;
        end else begin
            if ((state_q == S_IDLE) && start) begin
                m2p_q   <= dir_m2p;
                base_q  <= base;
                addr_q  <= base;
                plen_q  <= period_words;
                lastp_q <= last_period;
                burst_q <= burst_m1;
                word_q  <= '0;
                per_q   <= '0;
                beat_q  <= '0;
                prog_q  <= '0;
            end
            if ((state_q == S_MEM_RD) && mem_gnt)
                hold_q <= mem_rdata;
            if ((state_q == S_PERI_RX) && (rx_valid || !flow_en))
                hold_q <= rx_data;
            if (word_done) begin
                beat_q <= at_edge ? '0 : beat_q + 1'b1;
                if (last_word) begin
                    word_q <= '0;
                    prog_q <= prog_q + 1'b1;
                    if (per_q == lastp_q) begin
                        per_q  <= '0;
                        addr_q <= base_q;
                    end else begin
                        per_q  <= per_q + 1'b1;
                        addr_q <= addr_q + WORD_BYTES;
                    end
                end else begin
                    word_q <= word_q + 1'b1;
                    addr_q <= addr_q + WORD_BYTES;
                end
            end
        end
    end

    // Outputs from state
    always_comb begin
        mem_req   = (state_q == S_MEM_RD) || (state_q == S_MEM_WR);
        mem_we    = (state_q == S_MEM_WR);
        mem_addr  = addr_q;
        mem_wdata = hold_q;
        tx_valid  = (state_q == S_PERI_TX);
        tx_data   = hold_q;
        rx_ready  = (state_q == S_PERI_RX);
        busy      = (state_q != S_IDLE);
        paused    = (state_q == S_PAUSED);
        progress  = prog_q;
    end

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
    import ring_dma_pkg::*;
#(
    parameter int LEN_W   = 28,
    parameter int PER_W   = 3,
    parameter int BURST_W = 4,
    parameter int PROG_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [31:0] rx_data
);

    logic               start, run, pause_req, flow_en, dir_m2p;
    logic               busy, paused, period_done;
    logic [31:0]        base;
    logic [LEN_W-1:0]   period_words;
    logic [PER_W-1:0]   last_period;
    logic [BURST_W-1:0] burst_m1;
    logic [PROG_W-1:0]  progress;

    ring_dma_regs #(
        .LEN_W(LEN_W), .PER_W(PER_W), .BURST_W(BURST_W), .PROG_W(PROG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .paused(paused), .period_done(period_done), .progress(progress),
        .start(start), .run(run), .pause_req(pause_req), .flow_en(flow_en),
        .dir_m2p(dir_m2p), .base(base), .period_words(period_words),
        .last_period(last_period), .burst_m1(burst_m1), .irq(irq)
    );

    ring_dma_seq #(
        .DW(32), .LEN_W(LEN_W), .PER_W(PER_W), .BURST_W(BURST_W), .PROG_W(PROG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .run(run), .pause_req(pause_req), .flow_en(flow_en),
        .dir_m2p(dir_m2p), .base(base), .period_words(period_words),
        .last_period(last_period), .burst_m1(burst_m1),
        .busy(busy), .paused(paused), .period_done(period_done), .progress(progress),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
    parameter int PROG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              paused,
    input logic              period_done,
    input logic              flow_en,
    input logic              irq,
    input logic [PROG_W-1:0] progress,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic              mem_gnt,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [31:0]       tx_data,
    input logic              rx_ready
);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || tx_valid || rx_ready));

    a_r2_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, tx_valid, rx_ready}));

    a_r6_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !(mem_req || tx_valid || rx_ready));

    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(period_done));

    a_r8_progress_step: assert property (@(posedge clk) disable iff (!rst_n)
        (progress != $past(progress)) |-> ((progress == $past(progress) + 1'b1) || (progress == '0)));

    a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && flow_en) |=> (tx_valid && $stable(tx_data)));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

bind ring_dma_chan ring_dma_chk #(.PROG_W(PROG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .paused(paused),
    .period_done(period_done), .flow_en(flow_en), .irq(irq), .progress(progress),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_ready(rx_ready)
);

// File: tb/sim_ring_dma_chan.sv
module sim_ring_dma_chan;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, rx_valid, rx_ready;
    logic [31:0] tx_data, rx_data;

    int errors = 0;
    int checks = 0;

    // Memory and stream models
    logic [31:0] mem [0:255];
    int cyc = 0;
    int gnt_div = 1, rdy_div = 1, rxv_div = 1;
    bit rdy_en = 1'b1, rxv_en = 1'b1, flow_on = 1'b1;
    int ring_base = 0, ring_words = 1, tx0 = 0;
    int txcount = 0, rxcount = 0, wrcount = 0;
    int data_err = 0, range_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_dma_chan u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    initial begin
        mem_gnt = 1'b0; mem_rdata = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    end

    // Every handshake that completes at the next rising edge is logged here.
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_gnt = mem_req && ((cyc % gnt_div) == 0);
        if (mem_gnt) begin
            if (mem_addr[1:0] != 2'b00 || mem_addr < ring_base ||
                mem_addr >= ring_base + 4 * ring_words) range_err = range_err + 1;
            if (mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                wrcount = wrcount + 1;
            end else begin
                mem_rdata = mem[mem_addr[9:2]];
            end
        end
        tx_ready = rdy_en && ((cyc % rdy_div) == 0);
        if (tx_valid && (tx_ready || !flow_on)) begin
            if (tx_data !== mem[ring_base / 4 + ((txcount - tx0) % ring_words)])
                data_err = data_err + 1;
            txcount = txcount + 1;
        end
        rx_valid = rxv_en && ((cyc % rxv_div) == 0);
        rx_data  = 32'hB000_0000 + rxcount;
        if (rx_ready && (rx_valid || !flow_on)) rxcount = rxcount + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int dir, input bit flow, input bit hold);
        return (32'(dir) << 12) | (32'd2 << 8) | (32'(flow) << 1) | 32'(hold);
    endfunction

    // Program the channel and write 1 to the command register.
    task automatic setup(input int dir, input int basea, input int words,
                         input int nper, input int burst, input bit flow);
        ring_base = basea; ring_words = words * nper; tx0 = txcount; flow_on = flow;
        if (dir == 4) wr(8'h34, 32'(basea)); else wr(8'h3C, 32'(basea));
        wr(8'h44, 32'(words) << 2);
        wr(8'h28, (32'(nper - 1) << 28) | (32'(nper - 1) << 24) | (32'(burst - 1) << 20));
        wr(8'h24, ctrl_word(dir, flow, 1'b0));
        wr(8'h00, 32'd1);
    endtask

    task automatic stop_chan();
        logic [31:0] s;
        wr(8'h00, 32'd0);
        s = 32'd1;
        while (s[0]) rd(8'h0C, s);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk(v == 0, "R1 cmd after reset", v, 0);
        rd(8'h0C, v); chk(v == 0, "R1 status after reset", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 isr after reset", v, 0);
        rd(8'h54, v); chk(v == 0, "R1 progress after reset", v, 0);
        chk(!(irq || mem_req || tx_valid || rx_ready), "R1 idle outputs",
            {28'd0, irq, mem_req, tx_valid, rx_ready}, 0);
    endtask

    task automatic t_refuse();
        logic [31:0] v;
        setup(3, 32'h40, 4, 1, 1, 1'b1);
        repeat (4) @(negedge clk);
        rd(8'h0C, v); chk(v[0] == 1'b0, "R2 start refused bad direction", v, 0);
        rd(8'h00, v); chk(v[0] == 1'b0, "R2 cmd stays 0 on refusal", v, 0);
        setup(4, 32'h40, 0, 1, 1, 1'b1);
        repeat (4) @(negedge clk);
        rd(8'h0C, v); chk(v[0] == 1'b0, "R2 start refused zero length", v, 0);
    endtask

    task automatic t_m2p();
        logic [31:0] v;
        int e0, r0, n;
        e0 = data_err; r0 = range_err;
        gnt_div = 3; rdy_div = 2; rdy_en = 1'b1;
        setup(4, 32'h40, 3, 2, 2, 1'b1);
        rd(8'h0C, v); chk(v[0] == 1'b1, "R2 status busy while running", v, 1);
        while (txcount - tx0 < 14) @(negedge clk);
        stop_chan();
        n = txcount - tx0;
        chk((n % 3) == 0 || (n % 3) == 2, "R2 stop lands on burst boundary", n, 0);
        chk(data_err == e0, "R3 R5 tx words follow ring order with wrap", data_err - e0, 0);
        chk(range_err == r0, "R10 reads stay aligned inside ring", range_err - r0, 0);
        rd(8'h54, v); chk(v == n / 3, "R8 progress counts periods", v, n / 3);
        rd(8'h10, v); chk(v[0] && irq, "R7 isr set after periods", v, 1);
        wr(8'h1C, 32'd1);
        rd(8'h10, v); chk(v[0] == 1'b0 && !irq, "R7 isr cleared by write 1", v, 0);
        gnt_div = 1; rdy_div = 1;
    endtask

    task automatic t_p2m();
        logic [31:0] v;
        int rx0, w0, r0, n;
        mem[63] = 32'h5EED_0001; mem[70] = 32'h5EED_0002;
        r0 = range_err; rx0 = rxcount; w0 = wrcount;
        rxv_div = 2; rxv_en = 1'b1;
        setup(2, 32'h100, 2, 3, 1, 1'b1);
        while (wrcount - w0 < 8) @(negedge clk);
        stop_chan();
        n = wrcount - w0;
        for (int j = 0; j < 6; j++) begin
            if (n > j) begin
                int i;
                i = j + 6 * ((n - 1 - j) / 6);
                chk(mem[64 + j] == 32'hB000_0000 + rx0 + i, "R4 R5 ring slot holds latest rx word",
                    mem[64 + j], 32'hB000_0000 + rx0 + i);
            end
        end
        chk(mem[63] == 32'h5EED_0001 && mem[70] == 32'h5EED_0002, "R5 no write outside ring",
            mem[63] ^ mem[70], 32'h0000_0003);
        chk(range_err == r0, "R10 writes aligned inside ring", range_err - r0, 0);
        rd(8'h54, v); chk(v == n / 2, "R8 progress in peripheral to memory", v, n / 2);
        rd(8'h3C, v); chk(v[1:0] == 2'b00, "R10 target low bits read 0", v, 32'h100);
        rxv_div = 1;
    endtask

    task automatic t_pause();
        logic [31:0] v;
        int e0, snap;
        e0 = data_err;
        setup(4, 32'h80, 8, 1, 4, 1'b1);
        while (txcount - tx0 < 1) @(negedge clk);
        wr(8'h24, ctrl_word(4, 1'b1, 1'b1));
        v = 0;
        while (!v[1]) rd(8'h0C, v);
        snap = txcount - tx0;
        chk((snap % 4) == 0, "R6 pause at burst boundary", snap, 0);
        repeat (20) @(negedge clk);
        chk(txcount - tx0 == snap && !mem_req && !tx_valid, "R6 no activity while paused",
            txcount - tx0, snap);
        wr(8'h24, ctrl_word(4, 1'b1, 1'b0));
        while (txcount - tx0 < snap + 4) @(negedge clk);
        stop_chan();
        chk(data_err == e0, "R6 resume continues at next word", data_err - e0, 0);
    endtask

    task automatic t_flow();
        int snap;
        rdy_en = 1'b0;
        setup(4, 32'h40, 4, 1, 1, 1'b1);
        repeat (30) @(negedge clk);
        chk(txcount - tx0 == 0 && tx_valid, "R9 waits for ready with flow on", txcount - tx0, 0);
        rdy_en = 1'b1;
        stop_chan();
        rdy_en = 1'b0;
        setup(4, 32'h40, 4, 1, 1, 1'b0);
        snap = txcount;
        repeat (30) @(negedge clk);
        chk(txcount - snap >= 10, "R9 flow off ignores ready", txcount - snap, 10);
        stop_chan();
        rdy_en = 1'b1;
    endtask

    task automatic t_capture();
        logic [31:0] v;
        int e0, r0, n;
        e0 = data_err; r0 = range_err;
        setup(4, 32'h40, 4, 1, 4, 1'b0);
        wr(8'h34, 32'h200);
        wr(8'h44, 32'd4);
        wr(8'h24, ctrl_word(2, 1'b0, 1'b0));
        while (txcount - tx0 < 10) @(negedge clk);
        stop_chan();
        n = txcount - tx0;
        chk(data_err == e0 && range_err == r0, "R11 run keeps captured ring",
            data_err - e0 + range_err - r0, 0);
        rd(8'h54, v); chk(v == n / 4, "R11 captured period length", v, n / 4);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int e0, n;
        e0 = data_err;
        setup(4, 32'h40, 1, 1, 1, 1'b0);
        while (txcount - tx0 < 65538) @(negedge clk);
        stop_chan();
        n = txcount - tx0;
        rd(8'h54, v);
        chk(v == (n & 32'hFFFF) && n > 65536, "R8 progress wraps past 0xFFFF", v, n & 32'hFFFF);
        chk(data_err == e0, "R3 single word ring", data_err - e0, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_refuse();
        t_m2p();
        t_p2m();
        t_pause();
        t_flow();
        t_capture();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule